// File: doc/BRIEF.md
# Bit-Slice Corner-Turn Converter

This block turns a matrix of bits by ninety degrees between two kinds of stream. In the forward direction, packed floating-point elements arrive one per cycle, one lane at a time. Once a full tile of `LANES` elements is held, the block emits one bit-plane per cycle. Plane k carries bit k of every lane, with lane i at bit i of the plane. A bit-sliced arithmetic datapath can then work on all lanes at once. In the reverse direction, result bit-planes come back one per cycle. After a complete set has arrived, the block emits one packed result element per lane.

Each element is a 2-bit exception tag, a sign bit, `EXPW` exponent bits and `FRACW` fraction bits, packed from MSB to LSB in that order. The input element therefore has `NBITS = 3 + EXPW + FRACW` bits, which is 11 for a 5/3 format. A result element is one bit wider than an input element in standard mode (`3 + EXPW + FRACW + 1`). In extended mode it is `3 + EXPW + 2*FRACW + 1` bits wide, which is 15 for a 5/3 format. Two tile banks let one tile load while the other drains. The `rev_mode` input selects the direction and is captured at the first beat of each tile.

The write controller has three states. In FILL it accepts beats while its target bank is free. A forward beat that carries `in_flush` before the last lane moves FILL to PAD. PAD writes one zero element per cycle until the tile is full. Completing a tile in FILL or PAD moves to HOLD if the other bank is still occupied, and to FILL otherwise. HOLD returns to FILL once the bank frees. The read controller has two states. It goes from IDLE to SEND when the bank it points at is full. It returns from SEND to IDLE after the last beat of the tile is accepted, and then moves on to the other bank.

Top module: `bitslice_corner_turn`

## Requirements
- R1: During and just after reset, `out_valid` is 0. After reset is released, `in_ready` is 1.
- R2: In the forward direction, the plane with index k holds bit k of lane i's element at bit position i, for every lane of the tile.
- R3: Forward planes leave in descending bit order, from NBITS-1 down to 0, so the exception tag planes come first, then sign, exponent and fraction. `out_idx` gives the bit index, `out_rev` is 0, and `out_last` is 1 only on index 0.
- R4: No plane is offered before all LANES elements of a forward tile have been accepted.
- R5: A forward beat with `in_flush` = 1 ends the tile early. Lanes after the flushed one read as zero in every plane, and `in_ready` is 0 during the cycles spent padding.
- R6: While one full tile waits to drain, a second complete tile of LANES elements is accepted with no stall. With both banks full, `in_ready` is 0.
- R7: In the reverse direction, the first accepted plane is result bit RBITS-1 and later planes count down to bit 0. Elements leave from lane 0 upward, RBITS wide (15 for the 5/3 extended default), with `out_idx` = lane, `out_rev` = 1 and `out_last` only on lane LANES-1.
- R8: In the reverse direction, no element is offered before exactly RBITS planes have been accepted, and `in_flush` has no effect.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_idx`, `out_plane` and `out_elem` hold their values.
- R10: The direction is taken from `rev_mode` at the first beat of a tile. Changes of `rev_mode` later in the tile do not alter that tile's handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev_mode | input | 1 | 0: elements in, planes out; 1: planes in, elements out |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_flush | input | 1 | Forward only: this element ends a partial tile |
| in_elem | input | NBITS | Packed input element (forward) |
| in_plane | input | LANES | Result bit-plane (reverse) |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Consumer takes the output beat |
| out_rev | output | 1 | 1 when the beat is a reverse-direction element |
| out_last | output | 1 | Final beat of the tile |
| out_idx | output | CW | Bit index (forward) or lane index (reverse) |
| out_plane | output | LANES | Bit-plane (forward), zero otherwise |
| out_elem | output | RBITS | Result element (reverse), zero otherwise |

## Verification
The bench rebuilds every lane from the captured planes. A design with swapped row and column indexing, or with the plane order reversed, would return scrambled elements and wrong `out_idx` values. A flush in the middle of a tile must leave the unfilled lanes at zero and hold `in_ready` low while padding. A design that skipped padding would emit planes too early or leak stale lanes from the previous tile. Holding the consumer off while two tiles load catches a single-buffered design, which would stall the second tile. It also catches a design that overwrote the waiting bank. Reverse tiles carry a flush that must be ignored and a short wait before the final plane, and one forward tile toggles `rev_mode` part way through. A design that ended early or followed the live mode input would fail these.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {WR_FILL, WR_PAD, WR_HOLD} wr_state_t;
    typedef enum logic {RD_IDLE, RD_SEND} rd_state_t;

    // tag(2) + sign(1) + exponent + fraction
    function automatic int elem_bits(input int expw, input int fracw);
        return 3 + expw + fracw;
    endfunction

    // standard: one bit wider; extended: fraction doubled plus one
    function automatic int result_bits(input int expw, input int fracw, input int ext);
        return (ext != 0) ? (4 + expw + 2 * fracw) : (4 + expw + fracw);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ct_store.sv
module ct_store #(
    parameter int LANES = 32,
    parameter int W     = 15,
    parameter int LW    = 5,
    parameter int BW    = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic             wr_plane_mode,
    input  logic [LW-1:0]    wr_lane,
    input  logic [BW-1:0]    wr_bit,
    input  logic [W-1:0]     wr_word,
    input  logic [LANES-1:0] wr_lanes,
    input  logic             rd_bank,
    input  logic [LW-1:0]    rd_lane,
    input  logic [BW-1:0]    rd_bit,
    output logic [LANES-1:0] rd_lanes,
    output logic [W-1:0]     rd_word
);

    logic [W-1:0] lane_q [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [W-1:0] cell_q [2];

        always_ff @(posedge clk) begin
            if (wr_en) begin
                if (wr_plane_mode) begin
                    cell_q[wr_bank][wr_bit] <= wr_lanes[l];
                end else if (wr_lane == LW'(l)) begin
                    cell_q[wr_bank] <= wr_word;
                end
            end
        end

        assign lane_q[l]   = cell_q[rd_bank];
        assign rd_lanes[l] = cell_q[rd_bank][rd_bit];
    end

    assign rd_word = lane_q[rd_lane];

endmodule

// File: rtl/ct_writer.sv
module ct_writer
    import ct_pkg::*;
#(
    parameter int LANES = 32,
    parameter int NBITS = 11,
    parameter int RBITS = 15,
    parameter int LW    = 5,
    parameter int BW    = 4,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rev_mode,
    input  logic             in_valid,
    input  logic             in_flush,
    input  logic [NBITS-1:0] in_elem,
    input  logic [1:0]       bank_full,
    output logic             in_ready,
    output logic             wr_en,
    output logic             wr_bank,
    output logic             wr_plane_mode,
    output logic [LW-1:0]    wr_lane,
    output logic [BW-1:0]    wr_bit,
    output logic [RBITS-1:0] wr_word,
    output logic             fill_done,
    output logic             fill_rev
);

    localparam logic [CW-1:0] LTOP = CW'(LANES - 1);
    localparam logic [CW-1:0] RTOP = CW'(RBITS - 1);

    wr_state_t      st;
    logic           bank;
    logic [CW-1:0]  cnt;
    logic           cur_rev;

    logic           eff_rev;
    logic           beat;
    logic           last_beat;
    logic           pad_last;

    assign eff_rev   = (cnt == '0) ? rev_mode : cur_rev;
    assign last_beat = (cnt == (eff_rev ? RTOP : LTOP));
    assign pad_last  = (cnt == LTOP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= WR_FILL;
            bank    <= 1'b0;
            cnt     <= '0;
            cur_rev <= 1'b0;
        end else begin
            unique case (st)
                WR_FILL: begin
                    if (beat) begin
                        if (cnt == '0) cur_rev <= rev_mode;
                        if (last_beat) begin
                            cnt  <= '0;
                            bank <= ~bank;
                            st   <= bank_full[~bank] ? WR_HOLD : WR_FILL;
                        end else begin
                            cnt <= cnt + CW'(1);
                            if (!eff_rev && in_flush) st <= WR_PAD;
                        end
                    end
                end
                WR_PAD: begin
                    if (pad_last) begin
                        cnt  <= '0;
                        bank <= ~bank;
                        st   <= bank_full[~bank] ? WR_HOLD : WR_FILL;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                WR_HOLD: begin
                    if (!bank_full[bank]) st <= WR_FILL;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready      = (st == WR_FILL) && !bank_full[bank];
        beat          = in_valid && in_ready;
        wr_en         = beat || (st == WR_PAD);
        wr_bank       = bank;
        wr_plane_mode = beat && eff_rev;
        wr_lane       = cnt[LW-1:0];
        wr_bit        = BW'(RTOP - cnt);
        wr_word       = (st == WR_PAD) ? '0 : {{(RBITS-NBITS){1'b0}}, in_elem};
        fill_done     = (beat && last_beat) || ((st == WR_PAD) && pad_last);
        fill_rev      = (st == WR_FILL) && eff_rev;
    end

endmodule

// File: rtl/ct_reader.sv
module ct_reader
    import ct_pkg::*;
#(
    parameter int LANES = 32,
    parameter int NBITS = 11,
    parameter int LW    = 5,
    parameter int BW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          out_ready,
    input  logic [1:0]    bank_full,
    input  logic [1:0]    bank_rev,
    output logic          out_valid,
    output logic          out_last,
    output logic          out_rev,
    output logic [CW-1:0] out_idx,
    output logic          rd_bank,
    output logic [LW-1:0] rd_lane,
    output logic [BW-1:0] rd_bit,
    output logic          drain_done
);

    localparam logic [CW-1:0] LTOP = CW'(LANES - 1);
    localparam logic [CW-1:0] NTOP = CW'(NBITS - 1);

    rd_state_t     st;
    logic          bank;
    logic [CW-1:0] cnt;
    logic          is_last;

    assign is_last = (cnt == (bank_rev[bank] ? LTOP : NTOP));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RD_IDLE;
            bank <= 1'b0;
            cnt  <= '0;
        end else begin
            unique case (st)
                RD_IDLE: begin
                    if (bank_full[bank]) begin
                        st  <= RD_SEND;
                        cnt <= '0;
                    end
                end
                RD_SEND: begin
                    if (out_ready) begin
                        if (is_last) begin
                            st   <= RD_IDLE;
                            cnt  <= '0;
                            bank <= ~bank;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        out_valid  = (st == RD_SEND);
        out_rev    = bank_rev[bank];
        out_last   = out_valid && is_last;
        out_idx    = bank_rev[bank] ? cnt : (NTOP - cnt);
        rd_bank    = bank;
        rd_lane    = cnt[LW-1:0];
        rd_bit     = BW'(NTOP - cnt);
        drain_done = out_valid && out_ready && is_last;
    end

endmodule

// File: rtl/bitslice_corner_turn.sv
module bitslice_corner_turn
    import ct_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int EXPW     = 5,
    parameter int FRACW    = 3,
    parameter int EXTENDED = 1,
    localparam int NBITS   = elem_bits(EXPW, FRACW),
    localparam int RBITS   = result_bits(EXPW, FRACW, EXTENDED),
    localparam int CW      = $clog2(max2(LANES, RBITS))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rev_mode,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_flush,
    input  logic [NBITS-1:0] in_elem,
    input  logic [LANES-1:0] in_plane,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_rev,
    output logic             out_last,
    output logic [CW-1:0]    out_idx,
    output logic [LANES-1:0] out_plane,
    output logic [RBITS-1:0] out_elem
);

    localparam int LW = $clog2(LANES);
    localparam int BW = $clog2(RBITS);

    logic [1:0]       bank_full;
    logic [1:0]       bank_rev;

    logic             wr_en, wr_bank, wr_plane_mode;
    logic [LW-1:0]    wr_lane;
    logic [BW-1:0]    wr_bit;
    logic [RBITS-1:0] wr_word;
    logic             fill_done, fill_rev;

    logic             rd_bank, drain_done;
    logic [LW-1:0]    rd_lane;
    logic [BW-1:0]    rd_bit;
    logic [LANES-1:0] rd_lanes;
    logic [RBITS-1:0] rd_word;

    ct_writer #(
        .LANES(LANES), .NBITS(NBITS), .RBITS(RBITS),
        .LW(LW), .BW(BW), .CW(CW)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .rev_mode(rev_mode),
        .in_valid(in_valid), .in_flush(in_flush), .in_elem(in_elem),
        .bank_full(bank_full), .in_ready(in_ready),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_plane_mode(wr_plane_mode),
        .wr_lane(wr_lane), .wr_bit(wr_bit), .wr_word(wr_word),
        .fill_done(fill_done), .fill_rev(fill_rev)
    );

    ct_store #(
        .LANES(LANES), .W(RBITS), .LW(LW), .BW(BW)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_plane_mode(wr_plane_mode), .wr_lane(wr_lane), .wr_bit(wr_bit),
        .wr_word(wr_word), .wr_lanes(in_plane),
        .rd_bank(rd_bank), .rd_lane(rd_lane), .rd_bit(rd_bit),
        .rd_lanes(rd_lanes), .rd_word(rd_word)
    );

    ct_reader #(
        .LANES(LANES), .NBITS(NBITS), .LW(LW), .BW(BW), .CW(CW)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .out_ready(out_ready),
        .bank_full(bank_full), .bank_rev(bank_rev),
        .out_valid(out_valid), .out_last(out_last), .out_rev(out_rev),
        .out_idx(out_idx), .rd_bank(rd_bank), .rd_lane(rd_lane),
        .rd_bit(rd_bit), .drain_done(drain_done)
    );

    // bank occupancy: the writer sets, the reader clears (never the same bank)
    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_full[b] <= 1'b0;
                bank_rev[b]  <= 1'b0;
            end else begin
                if (fill_done && (wr_bank == b[0])) begin
                    bank_full[b] <= 1'b1;
                    bank_rev[b]  <= fill_rev;
                end else if (drain_done && (rd_bank == b[0])) begin
                    bank_full[b] <= 1'b0;
                end
            end
        end
    end

    assign out_plane = (out_valid && !out_rev) ? rd_lanes : '0;
    assign out_elem  = (out_valid &&  out_rev) ? rd_word  : '0;

endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int LANES = 32,
    parameter int RBITS = 15,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_rev,
    input logic             out_last,
    input logic [CW-1:0]    out_idx,
    input logic [LANES-1:0] out_plane,
    input logic [RBITS-1:0] out_elem
);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_idx)
            && $stable(out_plane) && $stable(out_elem));

    // R3
    plane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last && !out_rev
            |=> out_valid && (out_idx + CW'(1) == $past(out_idx)));

    // R3
    last_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last && !out_rev |-> out_idx == '0);

    // R7
    elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last && out_rev
            |=> out_valid && (out_idx == $past(out_idx) + CW'(1)));

    // R7
    last_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last && out_rev |-> out_idx == CW'(LANES - 1));

endmodule

bind bitslice_corner_turn ct_checker #(
    .LANES(LANES), .RBITS(RBITS), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_rev(out_rev), .out_last(out_last), .out_idx(out_idx),
    .out_plane(out_plane), .out_elem(out_elem)
);

// File: tb/tb_bitslice_corner_turn.sv
`timescale 1ns/1ps
module tb_bitslice_corner_turn;

    localparam int L  = 32;
    localparam int NB = 3 + 5 + 3;
    localparam int RB = 3 + 5 + 2 * 3 + 1;
    localparam int CWB = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rev_mode, in_valid, in_flush, out_ready;
    logic          in_ready, out_valid, out_rev, out_last;
    logic [NB-1:0] in_elem;
    logic [L-1:0]  in_plane;
    logic [CWB-1:0] out_idx;
    logic [L-1:0]  out_plane;
    logic [RB-1:0] out_elem;

    int total = 0;
    int bad   = 0;
    int waits = 0;

    logic [L-1:0]  gp [64];
    logic [RB-1:0] ge [64];
    int            gidx [64];
    logic          glast [64];
    logic          grev [64];
    int            gn;

    always #4 clk = ~clk;

    bitslice_corner_turn dut (
        .clk(clk), .rst_n(rst_n), .rev_mode(rev_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_flush(in_flush),
        .in_elem(in_elem), .in_plane(in_plane),
        .out_valid(out_valid), .out_ready(out_ready), .out_rev(out_rev),
        .out_last(out_last), .out_idx(out_idx),
        .out_plane(out_plane), .out_elem(out_elem)
    );

    task automatic chk(input string req, input longint act, input longint expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [NB-1:0] fv(input int i, input int s);
        return NB'(i * 37 + s * 113 + i * s * 5 + 3);
    endfunction

    function automatic logic [RB-1:0] rv(input int i, input int s);
        return RB'(i * 1291 + s * 4099 + (i << 9) + 21);
    endfunction

    task automatic put_elem(input logic [NB-1:0] d, input logic fl);
        in_elem = d; in_flush = fl; in_valid = 1'b1;
        while (!in_ready) begin @(negedge clk); waits++; end
        @(negedge clk);
        in_valid = 1'b0; in_flush = 1'b0;
    endtask

    task automatic put_plane(input logic [L-1:0] p, input logic fl);
        in_plane = p; in_flush = fl; in_valid = 1'b1;
        while (!in_ready) begin @(negedge clk); waits++; end
        @(negedge clk);
        in_valid = 1'b0; in_flush = 1'b0;
    endtask

    task automatic collect(input int n, input string req);
        int guard = 0;
        out_ready = 1'b1;
        gn = 0;
        while (gn < n && guard < 2000) begin
            if (out_valid) begin
                gp[gn] = out_plane; ge[gn] = out_elem; gidx[gn] = int'(out_idx);
                glast[gn] = out_last; grev[gn] = out_rev;
                gn++;
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        chk({req, " beat count"}, gn, n);
    endtask

    // planes at gp[base..]: order, flags and per-lane reconstruction
    task automatic check_fwd(input string req, input int base, input int seed, input int nvalid);
        for (int j = 0; j < NB; j++) begin
            chk({req, " plane index"}, gidx[base+j], NB - 1 - j);
            chk({req, " plane last"}, glast[base+j], (j == NB - 1));
            chk({req, " plane rev"}, grev[base+j], 0);
        end
        for (int i = 0; i < L; i++) begin
            logic [NB-1:0] v;
            for (int j = 0; j < NB; j++) v[NB-1-j] = gp[base+j][i];
            chk({req, " lane value"}, v, (i < nvalid) ? fv(i, seed) : '0);
        end
    endtask

    task automatic t_forward_basic();
        for (int i = 0; i < L - 1; i++) put_elem(fv(i, 1), 1'b0);
        repeat (3) @(negedge clk);
        chk("R4 no plane before full tile", out_valid, 0);
        put_elem(fv(L - 1, 1), 1'b0);
        collect(NB, "R3");
        check_fwd("R2", 0, 1, L);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 9; i++) put_elem(fv(i, 2), 1'b0);
        put_elem(fv(9, 2), 1'b1);
        chk("R5 in_ready low while padding", in_ready, 0);
        collect(NB, "R5");
        check_fwd("R5", 0, 2, 10);
    endtask

    task automatic t_double();
        for (int i = 0; i < L; i++) put_elem(fv(i, 3), 1'b0);
        waits = 0;
        for (int i = 0; i < L; i++) put_elem(fv(i, 4), 1'b0);
        chk("R6 second tile without stall", waits, 0);
        repeat (2) @(negedge clk);
        chk("R6 in_ready low with both banks full", in_ready, 0);
        collect(2 * NB, "R6");
        check_fwd("R6 first", 0, 3, L);
        check_fwd("R6 second", NB, 4, L);
    endtask

    task automatic t_reverse();
        rev_mode = 1'b1;
        for (int j = 0; j < RB - 1; j++) begin
            logic [L-1:0] p;
            for (int i = 0; i < L; i++) p[i] = rv(i, 5)[RB-1-j];
            put_plane(p, (j == 3));
            if (j == 3) chk("R8 flush ignored, in_ready stays high", in_ready, 1);
        end
        repeat (3) @(negedge clk);
        chk("R8 no element before all planes", out_valid, 0);
        begin
            logic [L-1:0] p;
            for (int i = 0; i < L; i++) p[i] = rv(i, 5)[0];
            put_plane(p, 1'b0);
        end
        rev_mode = 1'b0;
        collect(L, "R7");
        for (int i = 0; i < L; i++) begin
            chk("R7 element value", ge[i], rv(i, 5));
            chk("R7 lane index", gidx[i], i);
            chk("R7 rev flag", grev[i], 1);
            chk("R7 last flag", glast[i], (i == L - 1));
        end
    endtask

    task automatic t_backpressure();
        int guard = 0;
        for (int i = 0; i < L; i++) put_elem(fv(i, 6), 1'b0);
        gn = 0;
        while (gn < NB && guard < 2000) begin
            out_ready = guard[0];
            if (out_valid && !out_ready) begin
                logic [L-1:0] hp; int hi;
                hp = out_plane; hi = int'(out_idx);
                @(negedge clk); guard++;
                chk("R9 valid held", out_valid, 1);
                chk("R9 plane held", out_plane, hp);
                chk("R9 index held", out_idx, hi);
                continue;
            end
            if (out_valid) begin
                gp[gn] = out_plane; gidx[gn] = int'(out_idx);
                glast[gn] = out_last; grev[gn] = out_rev;
                gn++;
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        chk("R9 beat count", gn, NB);
        check_fwd("R9", 0, 6, L);
    endtask

    task automatic t_mode_latch();
        rev_mode = 1'b0;
        put_elem(fv(0, 7), 1'b0);
        rev_mode = 1'b1;
        for (int i = 1; i < L; i++) put_elem(fv(i, 7), 1'b0);
        rev_mode = 1'b0;
        collect(NB, "R10");
        check_fwd("R10", 0, 7, L);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rev_mode = 1'b0; in_valid = 1'b0; in_flush = 1'b0;
        out_ready = 1'b0; in_elem = '0; in_plane = '0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after reset", in_ready, 1);
        chk("R1 out_valid after reset", out_valid, 0);
        t_forward_basic();
        t_flush();
        t_double();
        t_reverse();
        t_backpressure();
        t_mode_latch();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule